// File: doc/BRIEF.md
# Dual-Style Parallel Host Bus Front End

This block is the host-side front end of a dot-matrix display controller. A host processor talks to it over an 8-bit parallel bus. There is one register-select line, and there are two control pins. The meaning of the control pins depends on the bus style chosen at reset:

- **Enable style:** the pins are an enable and a read/write select.
- **Strobe style:** the pins are separate active-low read and write strobes.

The block brings both control pins into the core clock domain through a synchroniser. It delays the data byte and the register-select line by the same number of cycles, so they stay aligned with the synchronised controls. It then turns every completed host transfer into exactly one single-cycle request towards the controller core. There are four request kinds: command write, display-data write, status read and display-data read.

During a host read, the block presents a byte that it registered when the read began. It asserts an output-enable for the pad ring only while the read is active.

Display-data reads are pipelined. The byte returned by the core for a read request lands in a read latch, and that latch is what the *next* data read shows on the bus. For this reason, the host performs a dummy read after changing the address.

The bus style is taken from the mode pin while reset is held. It stays fixed until the next reset.

Top module: `hostbus_front`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, all four request outputs are 0, `hostDoe` is 0, `hostDout` is 0 and `wrData` is 0.
- R2: The level of `modeSel` in the last cycle of reset selects the bus style: 1 selects enable style and 0 selects strobe style. Changes of `modeSel` after reset have no effect on how `ctlA`/`ctlB` are decoded.
- R3: In enable style, a write is `ctlA`=1 (enable) with `ctlB`=0 (write select). It is committed when the enable falls. `regSel`=1 gives one `dataWrReq` pulse and `regSel`=0 gives one `cmdWrReq` pulse. `wrData` carries the byte that was on `dataIn` while the enable was high.
- R4: In strobe style, a write is `ctlB`=0 (active-low write strobe). It is committed on the rising edge of `ctlB`, with the same request and `wrData` rules as R3.
- R5: Each committed write or started read produces exactly one request pulse, one cycle long. With `SYNC_STAGES`=2, a write request is high in the cycle after the third rising clock edge that follows the strobe release.
- R6: In enable style, a read is `ctlA`=1 with `ctlB`=1. Its start gives one `dataRdReq` pulse when `regSel`=1, or one `statusRdReq` pulse when `regSel`=0.
- R7: In strobe style, a read is `ctlA`=0 (active-low read strobe), with the same request rule as R6.
- R8: `hostDoe` is 1 only while a synchronised read is active, and it rises in the same cycle as the read request. It stays 0 during writes and when idle.
- R9: A status read shows on `hostDout` the value of `statusWord` at the start of the read. The value is held stable for the whole read.
- R10: A data read shows the read latch contents at the start of the read. The read latch holds the last `rspData` accepted with `rspValid`=1, and is 0 after reset. The response to the current read is shown only by the following data read.
- R11: The two write requests are never high together, and neither are the two read requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 1 | Bus style pin, sampled during reset (1 enable, 0 strobe) |
| regSel | input | 1 | 1 = display data, 0 = command/status |
| ctlA | input | 1 | Enable (enable style) or active-low read strobe (strobe style) |
| ctlB | input | 1 | Read/write select, 1 = read (enable style), or active-low write strobe (strobe style) |
| dataIn | input | DATA_W | Host data bus, inbound |
| hostDout | output | DATA_W | Host data bus, outbound |
| hostDoe | output | 1 | Output enable for the outbound bus |
| wrData | output | DATA_W | Byte carried with a write request |
| cmdWrReq | output | 1 | Command write request pulse |
| dataWrReq | output | 1 | Display-data write request pulse |
| statusRdReq | output | 1 | Status read request pulse |
| dataRdReq | output | 1 | Display-data read request pulse |
| rspValid | input | 1 | Core returns read data this cycle |
| rspData | input | DATA_W | Read data from the core |
| statusWord | input | DATA_W | Live status byte from the core |

## Verification
A wrong captured bus style shows at the ports on the first transfer after reset. Either no request appears, or requests appear with the wrong kind or wrong count, three cycles after the strobe moves.

A synchroniser or edge detector that is off by one moves the request pulse by a cycle, or doubles it. Timing the latency against the strobe release exposes this.

A read latch that updates in the wrong place shows up on the very next data read. The byte on the bus there is either the response to the current request or a stale value, when it should be the previous response. Status and data routing errors appear on the bus within the same read.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

  typedef enum logic {
    STYLE_STROBE = 1'b0,
    STYLE_ENABLE = 1'b1
  } busStyle_t;

  // strobes passed from control to datapath
  typedef struct packed {
    logic wrCapture;  // synchronised write phase active, keep sampling the byte
    logic wrCommit;   // write phase just ended
    logic rdStart;    // read phase just began
    logic rdActive;   // read phase in progress
  } ctrlStrb_t;

endpackage

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
  import hostbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeSel,
  input  logic       ctlA,
  input  logic       ctlB,
  output busStyle_t  styleQ,
  output ctrlStrb_t  strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncA;
  logic [SYNC_STAGES-1:0] syncB;
  logic idleLevel;
  logic aSync;
  logic bSync;
  logic wrAct;
  logic rdAct;
  logic prevWr;
  logic prevRd;

  // idle pin level: strobes rest high, the enable rests low
  assign idleLevel = ~modeSel;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncA <= idleLevel;
          syncB <= idleLevel;
        end else begin
          syncA <= ctlA;
          syncB <= ctlB;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncA <= {SYNC_STAGES{idleLevel}};
          syncB <= {SYNC_STAGES{idleLevel}};
        end else begin
          syncA <= {syncA[SYNC_STAGES-2:0], ctlA};
          syncB <= {syncB[SYNC_STAGES-2:0], ctlB};
        end
      end
    end
  endgenerate

  assign aSync = syncA[LAST];
  assign bSync = syncB[LAST];

  // style is loaded every reset cycle and frozen once reset is released
  always_ff @(posedge clk) begin
    if (!rstN) styleQ <= busStyle_t'(modeSel);
  end

  always_comb begin
    if (styleQ == STYLE_ENABLE) begin
      wrAct = aSync & ~bSync;
      rdAct = aSync & bSync;
    end else begin
      wrAct = ~bSync;
      rdAct = ~aSync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWr <= 1'b0;
      prevRd <= 1'b0;
    end else begin
      prevWr <= wrAct;
      prevRd <= rdAct;
    end
  end

  assign strb.wrCapture = wrAct;
  assign strb.wrCommit  = prevWr & ~wrAct;
  assign strb.rdStart   = rdAct & ~prevRd;
  assign strb.rdActive  = rdAct;

endmodule

// File: rtl/hostbus_dp.sv
module hostbus_dp
  import hostbus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrb_t         strb,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostDoe,
  output logic [DATA_W-1:0] wrData,
  output logic              cmdWrReq,
  output logic              dataWrReq,
  output logic              statusRdReq,
  output logic              dataRdReq
);

  localparam int PW   = DATA_W + 1;
  localparam int LAST = SYNC_STAGES - 1;

  // delay line matching the control synchroniser: {regSel, byte}
  logic [PW-1:0] pipe [SYNC_STAGES];

  generate
    for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_pipe
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rstN) pipe[gi] <= '0;
          else       pipe[gi] <= {regSel, dataIn};
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rstN) pipe[gi] <= '0;
          else       pipe[gi] <= pipe[gi-1];
        end
      end
    end
  endgenerate

  logic              alignedSel;
  logic [DATA_W-1:0] alignedByte;
  logic              holdSel;
  logic [DATA_W-1:0] holdByte;
  logic [DATA_W-1:0] readLatch;

  assign alignedSel  = pipe[LAST][DATA_W];
  assign alignedByte = pipe[LAST][DATA_W-1:0];

  // write holding register follows the bus while the write phase lasts
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdSel  <= 1'b0;
      holdByte <= '0;
    end else if (strb.wrCapture) begin
      holdSel  <= alignedSel;
      holdByte <= alignedByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWrReq  <= 1'b0;
      dataWrReq <= 1'b0;
      wrData    <= '0;
    end else begin
      cmdWrReq  <= strb.wrCommit & ~holdSel;
      dataWrReq <= strb.wrCommit & holdSel;
      if (strb.wrCommit) wrData <= holdByte;
    end
  end

  // read side: pipelined latch of core responses
  always_ff @(posedge clk) begin
    if (!rstN)         readLatch <= '0;
    else if (rspValid) readLatch <= rspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusRdReq <= 1'b0;
      dataRdReq   <= 1'b0;
      hostDout    <= '0;
      hostDoe     <= 1'b0;
    end else begin
      statusRdReq <= strb.rdStart & ~alignedSel;
      dataRdReq   <= strb.rdStart & alignedSel;
      hostDoe     <= strb.rdActive;
      if (strb.rdStart) hostDout <= alignedSel ? readLatch : statusWord;
    end
  end

endmodule

// File: rtl/hostbus_front.sv
module hostbus_front
  import hostbus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              regSel,
  input  logic              ctlA,
  input  logic              ctlB,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostDoe,
  output logic [DATA_W-1:0] wrData,
  output logic              cmdWrReq,
  output logic              dataWrReq,
  output logic              statusRdReq,
  output logic              dataRdReq,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  input  logic [DATA_W-1:0] statusWord
);

  busStyle_t styleQ;
  ctrlStrb_t strb;

  hostbus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .ctlA    (ctlA),
    .ctlB    (ctlB),
    .styleQ  (styleQ),
    .strb    (strb)
  );

  hostbus_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .regSel      (regSel),
    .dataIn      (dataIn),
    .strb        (strb),
    .rspValid    (rspValid),
    .rspData     (rspData),
    .statusWord  (statusWord),
    .hostDout    (hostDout),
    .hostDoe     (hostDoe),
    .wrData      (wrData),
    .cmdWrReq    (cmdWrReq),
    .dataWrReq   (dataWrReq),
    .statusRdReq (statusRdReq),
    .dataRdReq   (dataRdReq)
  );

endmodule

// File: rtl/hostbus_front_chk.sv
module hostbus_front_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              styleBit,
  input logic              hostDoe,
  input logic [DATA_W-1:0] hostDout,
  input logic              cmdWrReq,
  input logic              dataWrReq,
  input logic              statusRdReq,
  input logic              dataRdReq
);

  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdWrReq, dataWrReq})); // R11

  AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({statusRdReq, dataRdReq})); // R11

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrReq |=> !cmdWrReq); // R5

  AST_DAT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dataWrReq |=> !dataWrReq); // R5

  AST_RDREQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (statusRdReq || dataRdReq) |=> !(statusRdReq || dataRdReq)); // R5

  AST_RDREQ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (statusRdReq || dataRdReq) |-> hostDoe); // R8

  AST_OE_RISE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostDoe) |-> (statusRdReq || dataRdReq)); // R8

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (hostDoe && !(statusRdReq || dataRdReq)) |-> $stable(hostDout)); // R9

  AST_STYLE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(styleBit)); // R2

endmodule

bind hostbus_front hostbus_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .styleBit    (styleQ),
  .hostDoe     (hostDoe),
  .hostDout    (hostDout),
  .cmdWrReq    (cmdWrReq),
  .dataWrReq   (dataWrReq),
  .statusRdReq (statusRdReq),
  .dataRdReq   (dataRdReq)
);

// File: tb/hostbus_front_bench.sv
`timescale 1ns/1ps
module hostbus_front_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeSel = 1'b1;
  logic          regSel = 1'b0;
  logic          ctlA = 1'b0;
  logic          ctlB = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] hostDout;
  logic          hostDoe;
  logic [DW-1:0] wrData;
  logic          cmdWrReq, dataWrReq, statusRdReq, dataRdReq;
  logic          rspValid = 1'b0;
  logic [DW-1:0] rspData = '0;
  logic [DW-1:0] statusWord = '0;

  int total = 0;
  int bad = 0;
  bit curEnable;          // bench view of the style in force
  int nCmd = 0, nDat = 0, nSta = 0, nRd = 0;
  logic [DW-1:0] lastWr = '0;
  logic [DW-1:0] lastRsp = '0;
  bit rspPend = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hostbus_front #(.DATA_W(DW), .SYNC_STAGES(2)) u_hostbus_front (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .regSel(regSel),
    .ctlA(ctlA), .ctlB(ctlB), .dataIn(dataIn),
    .hostDout(hostDout), .hostDoe(hostDoe), .wrData(wrData),
    .cmdWrReq(cmdWrReq), .dataWrReq(dataWrReq),
    .statusRdReq(statusRdReq), .dataRdReq(dataRdReq),
    .rspValid(rspValid), .rspData(rspData), .statusWord(statusWord)
  );

  // monitor and core responder, both on the falling edge
  always @(negedge clk) begin
    if (rspValid) rspValid = 1'b0;
    if (cmdWrReq)  begin nCmd++; lastWr = wrData; end
    if (dataWrReq) begin nDat++; lastWr = wrData; end
    if (statusRdReq) nSta++;
    if (dataRdReq) begin
      nRd++;
      rspPend = 1;
    end else if (rspPend && rstN) begin
      rspPend  = 0;
      rspData  = DW'($urandom);
      rspValid = 1'b1;
      lastRsp  = rspData;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expRead(input bit sel, input logic [DW-1:0] st,
                                 input logic [DW-1:0] lat);
    return sel ? int'(lat) : int'(st);
  endfunction

  task automatic setIdle();
    if (curEnable) begin ctlA = 1'b0; ctlB = 1'b0; end
    else           begin ctlA = 1'b1; ctlB = 1'b1; end
  endtask

  task automatic doReset(input bit enableStyle);
    @(negedge clk);
    curEnable = enableStyle;
    modeSel = enableStyle;
    setIdle();
    rstN = 1'b0;
    rspPend = 0;
    repeat (3) @(negedge clk);
    check("R1 reqs in reset", {cmdWrReq, dataWrReq, statusRdReq, dataRdReq}, 0);
    rstN = 1'b1;
    lastRsp = '0;
    @(negedge clk);
    check("R1 oe after reset", hostDoe, 0);
    check("R1 dout after reset", hostDout, 0);
    check("R1 wrData after reset", wrData, 0);
    modeSel = ~enableStyle;   // R2: must be ignored from here on
    repeat (2) @(negedge clk);
  endtask

  task automatic busWrite(input bit sel, input logic [DW-1:0] b, input string tag);
    int c0, d0;
    c0 = nCmd; d0 = nDat;
    @(negedge clk);
    regSel = sel; dataIn = b;
    if (curEnable) begin ctlB = 1'b0; ctlA = 1'b1; end
    else           ctlB = 1'b0;
    repeat (4) @(negedge clk);
    check({tag, " R8 no oe on write"}, hostDoe, 0);
    if (curEnable) ctlA = 1'b0;
    else           ctlB = 1'b1;
    repeat (6) @(negedge clk);
    check({tag, " cmd count"}, nCmd - c0, sel ? 0 : 1);
    check({tag, " data count"}, nDat - d0, sel ? 1 : 0);
    check({tag, " wrData"}, lastWr, b);
    dataIn = DW'($urandom);
  endtask

  task automatic busRead(input bit sel, input string tag);
    int s0, r0, ex;
    s0 = nSta; r0 = nRd;
    @(negedge clk);
    regSel = sel;
    statusWord = DW'($urandom);
    ex = expRead(sel, statusWord, lastRsp);
    if (curEnable) begin ctlB = 1'b1; ctlA = 1'b1; end
    else           ctlA = 1'b0;
    repeat (4) @(negedge clk);
    check({tag, " R8 oe during read"}, hostDoe, 1);
    statusWord = ~statusWord;  // R9: later changes must not reach the bus
    @(negedge clk);
    check({tag, sel ? " R10 data byte" : " R9 status byte"}, hostDout, ex);
    if (curEnable) ctlA = 1'b0;
    else           ctlA = 1'b1;
    repeat (6) @(negedge clk);
    check({tag, " R8 oe released"}, hostDoe, 0);
    check({tag, " status req count"}, nSta - s0, sel ? 0 : 1);
    check({tag, " data req count"}, nRd - r0, sel ? 1 : 0);
    if (curEnable) ctlB = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2718));

    // enable style directed
    doReset(1'b1);
    busWrite(1'b0, 8'hA5, "R3 R2 enable cmd");
    busWrite(1'b1, 8'h3C, "R3 enable data");
    busRead(1'b1, "R6 first read");          // R10: returns reset latch 0
    busRead(1'b1, "R6 second read");         // R10: returns previous response
    busRead(1'b0, "R6 status");

    // strobe style directed
    doReset(1'b0);
    busWrite(1'b1, 8'h81, "R4 R2 strobe data");
    busWrite(1'b0, 8'h7E, "R4 strobe cmd");
    busRead(1'b0, "R7 status");
    busRead(1'b1, "R7 dummy");
    busRead(1'b1, "R7 real");

    // R5: exact latency of a write request
    begin
      int c0;
      c0 = nCmd;
      @(negedge clk);
      regSel = 1'b0; dataIn = 8'h5A; ctlB = 1'b0;
      repeat (4) @(negedge clk);
      ctlB = 1'b1;
      @(negedge clk); check("R5 latency edge1", cmdWrReq, 0);
      @(negedge clk); check("R5 latency edge2", cmdWrReq, 0);
      @(negedge clk); check("R5 latency edge3", cmdWrReq, 1);
      check("R5 latency wrData", wrData, 8'h5A);
      @(negedge clk); check("R5 single pulse", cmdWrReq, 0);
      repeat (4) @(negedge clk);
      check("R5 one pulse total", nCmd - c0, 1);
    end

    // random mix in both styles
    for (int st = 0; st < 2; st++) begin
      doReset(st == 0);
      for (int k = 0; k < 40; k++) begin
        bit s;
        s = 1'($urandom);
        if (($urandom % 2) == 0)
          busWrite(s, DW'($urandom), st == 0 ? "R3 rand" : "R4 rand");
        else
          busRead(s, st == 0 ? "R6 rand" : "R7 rand");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule